// File: doc/BRIEF.md
# SPI Controller with Mode-Fault Detection

This block is a byte-wide SPI port that can run as bus master or as slave. Software sets it up through an 8-bit control register, watches one completion flag in a status register, and moves bytes through a data register. All three sit behind a small register port. In master mode the block makes SCK from the system clock and shifts a byte out on MOSI while it shifts a byte in from MISO. In slave mode it follows an external SCK, and the slave-select input frames each byte.

The slave-select pin can be set up as a plain output. While the block is master it is then a general-purpose output with no effect on the port. If the pin is instead an input, any low level seen on it while the block is master means another master has taken the bus. The block then clears its own master bit and becomes a slave. It stops driving SCK and MOSI, and it raises the completion flag, which can also raise the interrupt. Master mode comes back only when software sets the master bit again. In slave mode, a rise of slave-select during a byte throws that byte away at once.

Top module: `spictl`

## Requirements
- R1: The control register is at address 0. Its bits are: 7 interrupt enable, 6 port enable, 5 LSB-first, 4 master, 3 clock polarity, 2 clock phase, 1:0 rate. The status register is at address 1, with the completion flag at bit 7 and every other bit reading 0. The data register is at address 2. At reset all control bits, the flag and every output enable are 0, and the control register reads back what was written to it.
- R2: In master mode, a write to the data register while no transfer is running starts an 8-bit transfer. SCK runs with a half period of 2, 8, 32 or 64 system clocks for rate 00, 01, 10 and 11. SCK and MOSI output enables are high while the port is enabled as master.
- R3: SCK rests at the clock-polarity level whenever no transfer is running. When clock phase is 0, data is sampled on the leading SCK edge (the edge away from the rest level); when it is 1, data is sampled on the trailing edge. Data changes on the other edge.
- R4: When LSB-first is 1, bit 0 goes out first and the first bit received lands in bit 0. When it is 0, bit 7 goes first. The same rule applies to both MOSI and MISO in both modes.
- R5: When a byte completes, the received byte can be read from the data register and the completion flag goes to 1. The interrupt output equals flag AND interrupt enable AND the global interrupt enable input.
- R6: The flag is cleared only by a status-register read made while the flag is 1, followed by a data-register read. A data-register read on its own leaves the flag set.
- R7: In slave mode with slave-select low, the block takes 8 bits from MOSI on its sample edges and then sets the flag. It drives the byte last written to the data register onto MISO, with the MISO enable high only while it is selected.
- R8: In slave mode, a rise of slave-select during a byte resets the bit count. The partial byte is dropped: the flag stays 0, the data register keeps its old value, and the next selected byte is received whole.
- R9: In slave mode with slave-select high, SCK and MOSI activity has no effect: no flag, no change to the data register, and MISO stays undriven.
- R10: In master mode with slave-select set up as an output, the level on the slave-select pin has no effect on the transfer or on the master bit.
- R11: In master mode with slave-select set up as an input, a low level on that pin clears the master bit and aborts any transfer. It also drops the SCK and MOSI output enables and sets the completion flag.
- R12: After a mode fault the master bit stays 0, even after slave-select goes high again, until software writes it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the flag-clear sequence) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| gie | input | 1 | Global interrupt enable |
| ss_dir_out | input | 1 | 1 when the slave-select pin is set up as an output |
| ss_i | input | 1 | Slave-select pin level, active low |
| sck_i | input | 1 | SCK pin level |
| sck_o | output | 1 | SCK drive value |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin level |
| mosi_o | output | 1 | MOSI drive value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin level |
| miso_o | output | 1 | MISO drive value |
| miso_oe | output | 1 | MISO output enable |
| irq | output | 1 | Interrupt request |

## Verification
Master transfers are run in all four polarity and phase combinations, with every rate and both bit orders. A slave model in the bench sends a different byte from the one the block sends, so a swapped edge, bit order or divider each shows up as a wrong byte or a wrong half period. Slave transfers run in two modes with distinct bytes each way. A partial byte cut off by slave-select is followed by a full byte, which separates a correct counter reset from a stale count. Clocking with slave-select high checks that the block ignores the bus. The mode fault is triggered in the middle of a transfer, and a second master run holds slave-select low with the pin set up as an output. Together these separate a monitored input from an ignored one.

// File: rtl/spictl_pkg.sv
package spictl_pkg;

    localparam int DW      = 8;
    localparam int BCNT_W  = $clog2(DW);
    localparam int EDGE_W  = $clog2(2 * DW);
    localparam int HALF_W  = 7;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    function automatic logic out_bit(input logic [DW-1:0] d, input logic lsb);
        return lsb ? d[0] : d[DW-1];
    endfunction

    function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] d, input logic b,
                                               input logic lsb);
        return lsb ? {b, d[DW-1:1]} : {d[DW-2:0], b};
    endfunction

    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate);
        case (rate)
            2'b00:   return HALF_W'(2);
            2'b01:   return HALF_W'(8);
            2'b10:   return HALF_W'(32);
            default: return HALF_W'(64);
        endcase
    endfunction

endpackage

// File: rtl/spictl_sync.sv
module spictl_sync #(
    parameter int             W      = 3,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= INIT;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= INIT;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spictl_clkdiv.sv
module spictl_clkdiv
    import spictl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] lim;

    assign lim  = half_period(rate) - HALF_W'(1);
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt_q <= '0;
        else if (cnt_q == lim) cnt_q <= '0;
        else                  cnt_q <= cnt_q + HALF_W'(1);
    end
endmodule

// File: rtl/spictl.sv
module spictl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       gie,
    input  logic       ss_dir_out,
    input  logic       ss_i,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    output logic       irq
);
    import spictl_pkg::*;

    ctrl_t             ctrl_q;
    logic              flag_q, armed_q, busy_q, sck_ph_q, tx_bit_q, sck_prev_q;
    logic [EDGE_W-1:0] edge_q;
    logic [BCNT_W-1:0] scnt_q;
    logic [DW-1:0]     sh_q, rx_q;
    logic              ss_s, sck_s, mosi_s;
    logic              tick;

    spictl_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_i, sck_i, mosi_i}),
        .q   ({ss_s, sck_s, mosi_s})
    );

    spictl_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_q),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    // Decoded conditions
    logic is_master, is_slave, slv_act, fault;
    logic wr_ctrl, wr_data, rd_stat, rd_data;
    logic m_sample, m_done, s_edge, s_lead, s_sample, s_done;
    logic [DW-1:0] m_next;

    assign is_master = ctrl_q.en & ctrl_q.master;
    assign is_slave  = ctrl_q.en & ~ctrl_q.master;
    assign slv_act   = is_slave & ~ss_s;
    assign fault     = is_master & ~ss_dir_out & ~ss_s;

    assign wr_ctrl = reg_wr && reg_addr == ADDR_CTRL;
    assign wr_data = reg_wr && reg_addr == ADDR_DATA;
    assign rd_stat = reg_rd && reg_addr == ADDR_STAT;
    assign rd_data = reg_rd && reg_addr == ADDR_DATA;

    // Master: even edge index = leading edge
    assign m_sample = tick && (edge_q[0] == ctrl_q.cpha);
    assign m_next   = m_sample ? shift_in(sh_q, miso_i, ctrl_q.lsb_first) : sh_q;
    assign m_done   = is_master && !fault && busy_q && tick
                      && edge_q == EDGE_W'(2 * DW - 1);

    // Slave: edges of the synchronised SCK
    assign s_edge   = slv_act && (sck_s != sck_prev_q);
    assign s_lead   = sck_s != ctrl_q.cpol;
    assign s_sample = s_edge && (s_lead != ctrl_q.cpha);
    assign s_done   = s_sample && scnt_q == BCNT_W'(DW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            flag_q     <= 1'b0;
            armed_q    <= 1'b0;
            busy_q     <= 1'b0;
            sck_ph_q   <= 1'b0;
            tx_bit_q   <= 1'b0;
            sck_prev_q <= 1'b0;
            edge_q     <= '0;
            scnt_q     <= '0;
            sh_q       <= '0;
            rx_q       <= '0;
        end else begin
            sck_prev_q <= sck_s;

            if (wr_ctrl)    ctrl_q        <= ctrl_t'(reg_wdata);
            else if (fault) ctrl_q.master <= 1'b0;

            if (fault || m_done || s_done) flag_q <= 1'b1;
            else if (armed_q && rd_data)   flag_q <= 1'b0;

            if (rd_data)                armed_q <= 1'b0;
            else if (rd_stat && flag_q) armed_q <= 1'b1;

            if (is_master) begin
                scnt_q <= '0;
                if (fault) begin
                    busy_q   <= 1'b0;
                    sck_ph_q <= 1'b0;
                    edge_q   <= '0;
                end else if (busy_q) begin
                    if (tick) begin
                        sck_ph_q <= ~sck_ph_q;
                        edge_q   <= edge_q + EDGE_W'(1);
                        sh_q     <= m_next;
                        if (!m_sample) tx_bit_q <= out_bit(sh_q, ctrl_q.lsb_first);
                        if (m_done) begin
                            busy_q <= 1'b0;
                            rx_q   <= m_next;
                        end
                    end
                end else if (wr_data) begin
                    busy_q   <= 1'b1;
                    edge_q   <= '0;
                    sck_ph_q <= 1'b0;
                    sh_q     <= reg_wdata;
                    tx_bit_q <= out_bit(reg_wdata, ctrl_q.lsb_first);
                end
            end else begin
                busy_q   <= 1'b0;
                sck_ph_q <= 1'b0;
                edge_q   <= '0;
                if (wr_data && scnt_q == '0) sh_q <= reg_wdata;
                if (!slv_act) begin
                    scnt_q   <= '0;
                    tx_bit_q <= out_bit(sh_q, ctrl_q.lsb_first);
                end else if (s_sample) begin
                    sh_q   <= shift_in(sh_q, mosi_s, ctrl_q.lsb_first);
                    scnt_q <= scnt_q + BCNT_W'(1);
                    if (s_done) rx_q <= shift_in(sh_q, mosi_s, ctrl_q.lsb_first);
                end else if (s_edge || scnt_q == '0) begin
                    tx_bit_q <= out_bit(sh_q, ctrl_q.lsb_first);
                end
            end
        end
    end

    assign sck_o   = ctrl_q.cpol ^ sck_ph_q;
    assign sck_oe  = is_master;
    assign mosi_o  = tx_bit_q;
    assign mosi_oe = is_master;
    assign miso_o  = tx_bit_q;
    assign miso_oe = slv_act;
    assign irq     = flag_q & ctrl_q.ie & gie;

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_STAT: reg_rdata = {flag_q, 7'b0};
            ADDR_DATA: reg_rdata = rx_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spictl_chk.sv
module spictl_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       master,
    input logic       cpol,
    input logic       ss_dir_out,
    input logic       ss_s,
    input logic       wr_ctrl,
    input logic       flag,
    input logic       busy,
    input logic [2:0] scnt,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       irq
);
    AST_FAULT_DEMOTE: assert property (@(posedge clk) disable iff (rst)
        en && master && !ss_dir_out && !ss_s && !wr_ctrl |=> !master && flag); // R11

    AST_DEMOTED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !master |-> !sck_oe && !mosi_oe); // R11

    AST_STAY_SLAVE: assert property (@(posedge clk) disable iff (rst)
        !master && !wr_ctrl |=> !master); // R12

    AST_DESELECT_RESET: assert property (@(posedge clk) disable iff (rst)
        en && !master && ss_s |=> scnt == 3'd0); // R8

    AST_SCK_REST: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck_o == cpol); // R3

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag); // R5
endmodule

bind spictl spictl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (ctrl_q.en),
    .master     (ctrl_q.master),
    .cpol       (ctrl_q.cpol),
    .ss_dir_out (ss_dir_out),
    .ss_s       (ss_s),
    .wr_ctrl    (reg_wr && reg_addr == 2'd0),
    .flag       (flag_q),
    .busy       (busy_q),
    .scnt       (scnt_q),
    .sck_o      (sck_o),
    .sck_oe     (sck_oe),
    .mosi_oe    (mosi_oe),
    .irq        (irq)
);

// File: tb/spictl_bench.sv
module spictl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b1, ss_dir_out = 1'b0, ss_i = 1'b1;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    spictl u_spictl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie), .ss_dir_out(ss_dir_out),
        .ss_i(ss_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
        .miso_oe(miso_oe), .irq(irq)
    );

    initial forever #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual cycle %0d expected end before 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int bit_at(input logic lsb, input int i);
        return lsb ? i : 7 - i;
    endfunction

    // Master transfer against a slave model run inside this task
    task automatic run_master(input logic cpol, input logic cpha, input logic lsb,
                              input logic [1:0] rate, input logic [7:0] tx,
                              input logic [7:0] pat, input string tag);
        int half, scnt, dcnt, last_t, last_half, idx;
        logic prev;
        logic [7:0] cap, d;
        half = (rate == 2'd0) ? 2 : (rate == 2'd1) ? 8 : (rate == 2'd2) ? 32 : 64;
        wr(2'd0, {1'b1, 1'b1, lsb, 1'b1, cpol, cpha, rate});
        waitn(1);
        scnt = 0; dcnt = 0; last_t = 0; last_half = 0; cap = 8'h00;
        miso_i = pat[bit_at(lsb, 0)];
        prev = sck_o;
        chk("R3", {tag, " sck rests at polarity"}, sck_o, cpol);
        chk("R2", {tag, " sck/mosi enables"}, {sck_oe, mosi_oe}, 2'b11);
        wr(2'd2, tx);
        for (int t = 0; t < 16 * half + 8; t++) begin
            @(negedge clk);
            if (sck_o !== prev) begin
                last_half = t - last_t;
                last_t = t;
                if ((sck_o != cpol) != cpha) begin
                    if (scnt < 8) cap[bit_at(lsb, scnt)] = mosi_o;
                    scnt++;
                end else begin
                    dcnt++;
                    idx = cpha ? dcnt - 1 : dcnt;
                    if (idx < 8) miso_i = pat[bit_at(lsb, idx)];
                end
            end
            prev = sck_o;
        end
        chk("R2", {tag, " sample edge count"}, scnt, 8);
        chk("R2", {tag, " sck half period"}, last_half, half);
        chk("R4", {tag, " byte seen on mosi"}, cap, tx);
        chk("R3", {tag, " sck back at rest"}, sck_o, cpol);
        chk("R5", {tag, " irq on completion"}, irq, 1'b1);
        rd(2'd2, d);
        chk("R4", {tag, " byte received"}, d, pat);
        rd(2'd1, d);
        chk("R6", {tag, " flag kept after data-only read"}, d, 8'h80);
        rd(2'd2, d);
        rd(2'd1, d);
        chk("R6", {tag, " flag cleared by status then data"}, d, 8'h00);
        chk("R6", {tag, " irq low after clear"}, irq, 1'b0);
    endtask

    // Bench acts as master toward the block in slave mode
    task automatic slv_xfer(input logic cpol, input logic cpha, input logic lsb,
                            input logic [7:0] b, input int nbits, output logic [7:0] got);
        got = 8'h00;
        sck_i = cpol;
        if (!cpha) mosi_i = b[bit_at(lsb, 0)];
        waitn(8);
        for (int i = 0; i < nbits; i++) begin
            if (cpha) begin
                mosi_i = b[bit_at(lsb, i)];
                sck_i = ~cpol;
                waitn(8);
                got[bit_at(lsb, i)] = miso_o;
                sck_i = cpol;
                waitn(8);
            end else begin
                sck_i = ~cpol;
                got[bit_at(lsb, i)] = miso_o;
                waitn(8);
                sck_i = cpol;
                if (i < 7) mosi_i = b[bit_at(lsb, i + 1)];
                waitn(8);
            end
        end
    endtask

    task automatic t_slave(input logic cpol, input logic cpha, input logic lsb,
                           input logic [7:0] dut_tx, input logic [7:0] bench_tx,
                           input string tag);
        logic [7:0] got, d;
        wr(2'd0, {1'b1, 1'b1, lsb, 1'b0, cpol, cpha, 2'b00});
        sck_i = cpol;
        waitn(4);
        wr(2'd2, dut_tx);
        waitn(4);
        ss_i = 1'b0;
        waitn(4);
        chk("R7", {tag, " miso enabled when selected"}, miso_oe, 1'b1);
        slv_xfer(cpol, cpha, lsb, bench_tx, 8, got);
        waitn(8);
        ss_i = 1'b1;
        waitn(6);
        chk("R7", {tag, " miso released when deselected"}, miso_oe, 1'b0);
        chk("R7", {tag, " byte driven on miso"}, got, dut_tx);
        rd(2'd1, d);
        chk("R7", {tag, " flag after 8 bits"}, d, 8'h80);
        rd(2'd2, d);
        chk("R7", {tag, " byte received"}, d, bench_tx);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd0, d);
        chk("R1", "control after reset", d, 8'h00);
        rd(2'd1, d);
        chk("R1", "status after reset", d, 8'h00);
        chk("R1", "enables and irq after reset", {sck_oe, mosi_oe, miso_oe, irq}, 4'b0000);
        wr(2'd0, 8'hA7);
        rd(2'd0, d);
        chk("R1", "control readback", d, 8'hA7);
    endtask

    task automatic t_ss_output;
        logic [7:0] d;
        ss_dir_out = 1'b1;
        ss_i = 1'b0;
        run_master(1'b0, 1'b0, 1'b0, 2'b00, 8'h6B, 8'hD2, "R10 ss-output");
        rd(2'd0, d);
        chk("R10", "master bit kept with ss low as output", d[4], 1'b1);
        ss_i = 1'b1;
        ss_dir_out = 1'b0;
        waitn(4);
    endtask

    task automatic t_fault;
        logic [7:0] d;
        ss_dir_out = 1'b0;
        ss_i = 1'b1;
        wr(2'd0, 8'hD1);
        wr(2'd2, 8'h55);
        waitn(20);
        ss_i = 1'b0;
        waitn(6);
        rd(2'd0, d);
        chk("R11", "master bit cleared by fault", d, 8'hC1);
        chk("R11", "sck/mosi enables dropped", {sck_oe, mosi_oe}, 2'b00);
        rd(2'd1, d);
        chk("R11", "flag set by fault", d, 8'h80);
        chk("R11", "irq raised by fault", irq, 1'b1);
        gie = 1'b0;
        waitn(1);
        chk("R5", "irq masked by global enable", irq, 1'b0);
        gie = 1'b1;
        ss_i = 1'b1;
        waitn(30);
        rd(2'd0, d);
        chk("R12", "master stays cleared after ss high", d[4], 1'b0);
        rd(2'd2, d);
        wr(2'd0, 8'hD1);
        rd(2'd0, d);
        chk("R12", "master restored by software write", d, 8'hD1);
        chk("R12", "sck enable back after rewrite", sck_oe, 1'b1);
    endtask

    task automatic t_abort;
        logic [7:0] got, d;
        wr(2'd0, 8'h40);
        sck_i = 1'b0;
        waitn(4);
        ss_i = 1'b0;
        waitn(4);
        slv_xfer(1'b0, 1'b0, 1'b0, 8'hF0, 4, got);
        ss_i = 1'b1;
        waitn(8);
        rd(2'd1, d);
        chk("R8", "no flag after aborted byte", d, 8'h00);
        rd(2'd2, d);
        chk("R8", "data kept after aborted byte", d, 8'h3E);
        ss_i = 1'b0;
        waitn(4);
        slv_xfer(1'b0, 1'b0, 1'b0, 8'h96, 8, got);
        waitn(8);
        ss_i = 1'b1;
        waitn(6);
        rd(2'd1, d);
        chk("R8", "flag after full byte following abort", d, 8'h80);
        rd(2'd2, d);
        chk("R8", "full byte after abort", d, 8'h96);
    endtask

    task automatic t_ignore;
        logic [7:0] got, d;
        ss_i = 1'b1;
        slv_xfer(1'b0, 1'b0, 1'b0, 8'hFF, 8, got);
        waitn(8);
        rd(2'd1, d);
        chk("R9", "no flag while deselected", d, 8'h00);
        chk("R9", "miso undriven while deselected", miso_oe, 1'b0);
        rd(2'd2, d);
        chk("R9", "data unchanged while deselected", d, 8'h96);
        ss_i = 1'b0;
        waitn(4);
        slv_xfer(1'b0, 1'b0, 1'b0, 8'h42, 8, got);
        waitn(8);
        ss_i = 1'b1;
        waitn(6);
        rd(2'd1, d);
        rd(2'd2, d);
        chk("R9", "byte received after reselect", d, 8'h42);
    endtask

    initial begin
        waitn(3);
        rst = 1'b0;
        waitn(2);
        t_reset();
        run_master(1'b0, 1'b0, 1'b0, 2'b00, 8'hA5, 8'h3C, "mode0 msb rate0");
        run_master(1'b1, 1'b1, 1'b1, 2'b01, 8'h1E, 8'hC3, "mode3 lsb rate1");
        run_master(1'b0, 1'b1, 1'b0, 2'b10, 8'h81, 8'h7E, "mode1 msb rate2");
        run_master(1'b1, 1'b0, 1'b1, 2'b11, 8'h4D, 8'hB2, "mode2 lsb rate3");
        t_ss_output();
        t_fault();
        t_slave(1'b0, 1'b0, 1'b0, 8'h3C, 8'hA5, "slave mode0 msb");
        t_slave(1'b1, 1'b1, 1'b1, 8'h81, 8'h3E, "slave mode3 lsb");
        t_abort();
        t_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule